// File: doc/BRIEF.md
# Multi-Function Arithmetic and Logic Unit with Multiply

A purely combinational 32-bit arithmetic and logic unit for the execute stage of a small load/store core. It takes two operands and a 4-bit operation code. It returns a 32-bit result and a flag that shows whether the two operands are equal. Addition, subtraction, the three bitwise logic operations, three shifts, two set-less-than compares and three multiply variants are all evaluated at the same time. A final selector then forwards the one result that the operation code names.

The multiply variants return either the low word of the product or its high word. The high word comes in a signed form and an unsigned form. Addition and subtraction wrap silently. The unit raises no overflow flag and has no divider. The instruction decoder sets the operation code, and the equality flag feeds branch resolution.

Top module: `arith_logic_unit`

## Requirements
- R1: Code 0 returns opnd_a + opnd_b modulo 2^32, with no overflow indication.
- R2: Code 12 returns opnd_a - opnd_b modulo 2^32.
- R3: Codes 1, 2 and 3 return the bitwise AND, OR and XOR of the operands.
- R4: Code 4 shifts opnd_a right and fills with zeros. Code 5 shifts it right and copies the sign bit in. Code 6 shifts it left. In all three, the shift distance is opnd_b[4:0] and bits 31..5 of opnd_b are ignored.
- R5: Code 8 returns 1 when opnd_a < opnd_b as two's-complement values, and 0 otherwise. Code 9 does the same with an unsigned compare.
- R6: Code 10 returns bits 31..0 of the product opnd_a * opnd_b.
- R7: Code 14 returns bits 63..32 of the 64-bit two's-complement product.
- R8: Code 11 returns bits 63..32 of the 64-bit unsigned product.
- R9: Codes 7, 13 and 15 are unassigned and return a result of zero.
- R10: eq_flag is 1 exactly when opnd_a - opnd_b is zero, for every operation code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand; the value that is shifted for codes 4 to 6 |
| opnd_b | input | 32 | Second operand; its low 5 bits give the shift distance |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Result of the selected operation |
| eq_flag | output | 1 | 1 when the operands are equal |

## Verification
The bound checker checks, whenever any input changes, the following:
- The equality flag against a direct compare of the operands, for every code.
- That the three unassigned codes return zero.
- That the compare codes never set any bit above bit 0.
- That addition and subtraction invert each other.
- That XOR undoes itself.
- That a shift by distance zero returns the operand unchanged, whatever bits 31..5 of opnd_b hold.

The exact values of the multiply high words, the sign fill of the arithmetic shift, and the difference between the signed and unsigned compares show up only in the bench's vector table and directed cases. That is also true of the wrap-around at the edges of the 32-bit range.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_AND   = 4'd1,
    OP_OR    = 4'd2,
    OP_XOR   = 4'd3,
    OP_SHR   = 4'd4,
    OP_SAR   = 4'd5,
    OP_SHL   = 4'd6,
    OP_LTS   = 4'd8,
    OP_LTU   = 4'd9,
    OP_MULLO = 4'd10,
    OP_MULHU = 4'd11,
    OP_SUB   = 4'd12,
    OP_MULHS = 4'd14
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_RIGHT_LOG = 2'd0,
    SH_RIGHT_ARI = 2'd1,
    SH_LEFT      = 2'd2
  } shift_kind_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff,
  output logic         diff_zero
);
  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] x, input logic [W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [W-1:0] wrap_sub(input logic [W-1:0] x, input logic [W-1:0] y);
    return x + (~y) + {{(W-1){1'b0}}, 1'b1};
  endfunction

  assign sum       = wrap_add(a, b);
  assign diff      = wrap_sub(a, b);
  assign diff_zero = (diff == '0);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   shr_log,
  output logic [W-1:0]   shr_ari,
  output logic [W-1:0]   shl
);
  import alu_pkg::*;

  function automatic logic [W-1:0] do_shift(input logic [W-1:0] x,
                                            input logic [SHW-1:0] n,
                                            input shift_kind_e k);
    logic [W-1:0] r;
    case (k)
      SH_RIGHT_LOG: r = x >> n;
      SH_RIGHT_ARI: r = W'($signed(x) >>> n);
      default:      r = x << n;
    endcase
    return r;
  endfunction

  assign shr_log = do_shift(a, amt, SH_RIGHT_LOG);
  assign shr_ari = do_shift(a, amt, SH_RIGHT_ARI);
  assign shl     = do_shift(a, amt, SH_LEFT);
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt_signed,
  output logic         lt_unsigned
);
  function automatic logic less(input logic [W-1:0] x, input logic [W-1:0] y,
                                input logic as_signed);
    logic [W-1:0] xf, yf;
    xf = {x[W-1] ^ as_signed, x[W-2:0]};
    yf = {y[W-1] ^ as_signed, y[W-2:0]};
    return xf < yf;
  endfunction

  assign lt_signed   = less(a, b, 1'b1);
  assign lt_unsigned = less(a, b, 1'b0);
endmodule

// File: rtl/alu_multiplier.sv
module alu_multiplier #(
  parameter int W = 32,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         signed_mode,
  output logic [W-1:0] prod_lo,
  output logic [W-1:0] prod_hi
);
  function automatic logic [PW-1:0] widen(input logic [W-1:0] x, input logic sgn);
    return {{W{sgn & x[W-1]}}, x};
  endfunction

  logic [PW-1:0] prod;
  assign prod    = widen(a, signed_mode) * widen(b, signed_mode);
  assign prod_lo = prod[W-1:0];
  assign prod_hi = prod[PW-1:W];
endmodule

// File: rtl/arith_logic_unit.sv
module arith_logic_unit #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [3:0]   op_sel,
  output logic [W-1:0] result,
  output logic         eq_flag
);
  import alu_pkg::*;

  logic [W-1:0] sum_val, diff_val;
  logic         diff_zero;
  logic [W-1:0] shr_log_val, shr_ari_val, shl_val;
  logic         lt_s, lt_u;
  logic [W-1:0] mul_lo_val, mul_hi_val;
  logic         mul_signed;

  alu_addsub #(.W(W)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sum(sum_val), .diff(diff_val), .diff_zero(diff_zero)
  );

  alu_shifter #(.W(W)) u_shift (
    .a(opnd_a), .amt(opnd_b[SHW-1:0]),
    .shr_log(shr_log_val), .shr_ari(shr_ari_val), .shl(shl_val)
  );

  alu_compare #(.W(W)) u_cmp (
    .a(opnd_a), .b(opnd_b), .lt_signed(lt_s), .lt_unsigned(lt_u)
  );

  // The low word is the same in both modes; only the unsigned-high code clears it.
  assign mul_signed = (op_sel != OP_MULHU);

  alu_multiplier #(.W(W)) u_mul (
    .a(opnd_a), .b(opnd_b), .signed_mode(mul_signed),
    .prod_lo(mul_lo_val), .prod_hi(mul_hi_val)
  );

  function automatic logic [W-1:0] bit_to_word(input logic v);
    return {{(W-1){1'b0}}, v};
  endfunction

  always_comb begin
    case (op_sel)
      OP_ADD:   result = sum_val;
      OP_AND:   result = opnd_a & opnd_b;
      OP_OR:    result = opnd_a | opnd_b;
      OP_XOR:   result = opnd_a ^ opnd_b;
      OP_SHR:   result = shr_log_val;
      OP_SAR:   result = shr_ari_val;
      OP_SHL:   result = shl_val;
      OP_LTS:   result = bit_to_word(lt_s);
      OP_LTU:   result = bit_to_word(lt_u);
      OP_MULLO: result = mul_lo_val;
      OP_MULHU: result = mul_hi_val;
      OP_SUB:   result = diff_val;
      OP_MULHS: result = mul_hi_val;
      default:  result = '0;
    endcase
  end

  assign eq_flag = diff_zero;
endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int W = 32
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [3:0]   op_sel,
  input logic [W-1:0] result,
  input logic         eq_flag,
  input logic [W-1:0] sum_val,
  input logic [W-1:0] diff_val
);
  always_comb begin
    // R10
    eq_match_chk: assert (eq_flag == (opnd_a == opnd_b))
      else $error("eq_flag mismatch");
    // R9
    if (op_sel == 4'd7 || op_sel == 4'd13 || op_sel == 4'd15)
      unused_zero_chk: assert (result == '0) else $error("unused code nonzero");
    // R5
    if (op_sel == 4'd8 || op_sel == 4'd9)
      lt_width_chk: assert (result[W-1:1] == '0) else $error("compare upper bits set");
    // R1
    if (op_sel == 4'd0)
      add_inverse_chk: assert (result - opnd_b == opnd_a) else $error("add inverse");
    // R2
    sub_inverse_chk: assert (diff_val + opnd_b == opnd_a) else $error("sub inverse");
    // R1
    add_commute_chk: assert (sum_val - opnd_a == opnd_b) else $error("sum inverse");
    // R3
    if (op_sel == 4'd3)
      xor_inverse_chk: assert ((result ^ opnd_b) == opnd_a) else $error("xor inverse");
    // R4
    if ((op_sel == 4'd4 || op_sel == 4'd5 || op_sel == 4'd6) && opnd_b[4:0] == 5'd0)
      shift_zero_chk: assert (result == opnd_a) else $error("zero shift changed value");
  end
endmodule

bind arith_logic_unit alu_checker #(.W(W)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .result(result),
  .eq_flag(eq_flag), .sum_val(sum_val), .diff_val(diff_val)
);

// File: tb/arith_logic_unit_test.sv
module arith_logic_unit_test;
  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  sel;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{8'd1,  4'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000}, // R1 wrap
    '{8'd1,  4'd0,  32'h12345678, 32'h11111111, 32'h23456789}, // R1
    '{8'd2,  4'd12, 32'h00000005, 32'h00000007, 32'hFFFFFFFE}, // R2 wrap
    '{8'd2,  4'd12, 32'h80000000, 32'h00000001, 32'h7FFFFFFF}, // R2
    '{8'd3,  4'd1,  32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000}, // R3 and
    '{8'd3,  4'd2,  32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFFF0F0}, // R3 or
    '{8'd3,  4'd3,  32'hFFFF0000, 32'h0F0F0F0F, 32'hF0F00F0F}, // R3 xor
    '{8'd4,  4'd4,  32'h80000000, 32'h00000004, 32'h08000000}, // R4 logical right
    '{8'd4,  4'd5,  32'h80000000, 32'h00000004, 32'hF8000000}, // R4 sign fill
    '{8'd4,  4'd6,  32'h00000001, 32'h0000001F, 32'h80000000}, // R4 left
    '{8'd4,  4'd4,  32'h80000000, 32'h00000024, 32'h08000000}, // R4 upper bits ignored
    '{8'd4,  4'd6,  32'h0000000F, 32'hFFFFFFE0, 32'h0000000F}, // R4 distance zero
    '{8'd5,  4'd8,  32'hFFFFFFFF, 32'h00000001, 32'h00000001}, // R5 signed
    '{8'd5,  4'd9,  32'hFFFFFFFF, 32'h00000001, 32'h00000000}, // R5 unsigned
    '{8'd5,  4'd8,  32'h00000005, 32'h00000005, 32'h00000000}, // R5 equal
    '{8'd5,  4'd9,  32'h00000001, 32'hFFFFFFFF, 32'h00000001}, // R5
    '{8'd6,  4'd10, 32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFE}, // R6
    '{8'd6,  4'd10, 32'h00010000, 32'h00010000, 32'h00000000}, // R6 overflowing low word
    '{8'd7,  4'd14, 32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFF}, // R7
    '{8'd7,  4'd14, 32'h80000000, 32'h80000000, 32'h40000000}, // R7
    '{8'd8,  4'd11, 32'hFFFFFFFF, 32'h00000002, 32'h00000001}, // R8
    '{8'd8,  4'd11, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE}, // R8
    '{8'd8,  4'd11, 32'h80000000, 32'h80000000, 32'h40000000}, // R8
    '{8'd9,  4'd7,  32'h12345678, 32'h00000009, 32'h00000000}, // R9
    '{8'd9,  4'd13, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}, // R9
    '{8'd9,  4'd15, 32'hDEADBEEF, 32'h00000003, 32'h00000000}  // R9
  };

  logic        clk = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [3:0]  op_sel = '0;
  logic [31:0] result;
  logic        eq_flag;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  arith_logic_unit uut (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
    .result(result), .eq_flag(eq_flag)
  );

  task automatic apply_check(input int req, input logic [3:0] s, input logic [31:0] a,
                             input logic [31:0] b, input logic [31:0] exp);
    @(posedge clk);
    op_sel = s; opnd_a = a; opnd_b = b;
    @(negedge clk);
    n_run++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL R%0d result code %0d: got %h expected %h", req, s, result, exp);
    end
    n_run++;
    if (eq_flag !== (a == b)) begin
      n_fail++;
      $display("FAIL R10 eq_flag code %0d: got %b expected %b", s, eq_flag, (a == b));
    end
  endtask

  initial begin
    // Idle state: all-zero inputs, add of zeros, R10 equality set
    apply_check(1, 4'd0, 32'h0, 32'h0, 32'h0);
    for (int i = 0; i < NV; i++)
      apply_check(int'(VECS[i].req), VECS[i].sel, VECS[i].a, VECS[i].b, VECS[i].exp);
    // R10: flag set under a logic code with equal nonzero operands
    apply_check(3, 4'd1, 32'hAAAAAAAA, 32'hAAAAAAAA, 32'hAAAAAAAA);
    // R10: flag clear under subtract with unequal operands
    apply_check(2, 4'd12, 32'h00000000, 32'h80000000, 32'h80000000);
    // R4: arithmetic shift of a positive value by 31
    apply_check(4, 4'd5, 32'h7FFFFFFF, 32'h0000001F, 32'h00000000);
    // R7: signed high word of min times -1 is zero
    apply_check(7, 4'd14, 32'h80000000, 32'hFFFFFFFF, 32'h00000000);
    // R8: unsigned high word of the same operands
    apply_check(8, 4'd11, 32'h80000000, 32'hFFFFFFFF, 32'h7FFFFFFF);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule